// File: doc/BRIEF.md
# ADC Start Trigger Selector

This block turns events from a motor-control timer pair into start pulses for two analog-to-digital converters. Each converter has its own trigger output. Four event strobes come in. The main timer supplies a counter underflow and a cycle match. A secondary tuning timer supplies two compare matches. Each output has its own four-bit source selection. All selected sources that qualify in a cycle are OR-ed, and the result is registered into a single-cycle trigger pulse.

The two main-timer events arrive already thinned by the interrupt thinning logic, which sits outside this block. Each of them counts only while its interrupt-output enable input is high. The tuning-timer compare events are qualified by the count direction of the main timer instead. For every output and every compare source there is a direction-mask bit. When the bit is clear, the event passes only while the main counter counts up. When the bit is set, it passes only while the main counter counts down.

Configuration lives in two small registers that are loaded through a one-word write port. A synchronous active-low reset clears both registers, and after reset no source is selected.

Top module: `adtrig_sel`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) forces both trigger outputs low and clears the select and mask registers, so no event produces a trigger afterwards until software writes new configuration.
- R2: The underflow strobe produces a trigger on output 0 when select bit 0 is set, and on output 1 when select bit 4 is set, but only while uf_irq_en is high. The trigger is high in the cycle after the strobe.
- R3: While uf_irq_en is low, underflow strobes never produce a trigger. While cm_irq_en is low, cycle-match strobes never produce a trigger.
- R4: The cycle-match strobe produces a trigger on output 0 when select bit 1 is set, and on output 1 when select bit 5 is set, but only while cm_irq_en is high.
- R5: Compare 0 is selected by select bit 2 (output 0) or bit 6 (output 1). Compare 1 is selected by bit 3 (output 0) or bit 7 (output 1). When the matching mask bit is 0, a compare strobe qualifies only if cnt_down is 0 in the same cycle. The mask bits are: bit 0 for output 0 compare 0, bit 1 for output 0 compare 1, bit 2 for output 1 compare 0, and bit 3 for output 1 compare 1.
- R6: When the matching mask bit is 1, a compare strobe qualifies only if cnt_down is 1 in the same cycle. It is blocked while the main counter counts up.
- R7: cnt_down has no effect on underflow or cycle-match triggers.
- R8: All qualifying selected sources of an output are OR-ed. When several coincide in one cycle, the output is high for exactly one cycle.
- R9: The two outputs are independent. Each output responds only to its own select and mask bits.
- R10: A write with cfg_we high and cfg_addr 0 loads cfg_wdata[7:0] into the select register. A write with cfg_addr 1 loads cfg_wdata[3:0] into the mask register and leaves the select register unchanged. A written value applies to strobes from the next cycle on; a strobe in the write cycle uses the old value.
- R11: A trigger output is high only in the cycle after a qualifying strobe. In all other cycles it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select: 0 for source select, 1 for direction mask |
| cfg_wdata | input | 8 | Configuration write data |
| uf_evt | input | 1 | Thinned underflow strobe from the main timer |
| cm_evt | input | 1 | Thinned cycle-match strobe from the main timer |
| cmp0_evt | input | 1 | Compare 0 match strobe from the tuning timer |
| cmp1_evt | input | 1 | Compare 1 match strobe from the tuning timer |
| uf_irq_en | input | 1 | Underflow interrupt-output enable |
| cm_irq_en | input | 1 | Cycle-match interrupt-output enable |
| cnt_down | input | 1 | Main counter direction: 0 counts up, 1 counts down |
| adc_trig | output | 2 | Registered trigger pulses; bit n drives converter n |

## Verification
The bench sends each compare source through both mask polarities in both count directions. A design with an inverted or swapped mask would let a blocked compare through, or swallow a permitted one. It sets the direction flag against underflow and cycle-match events to catch masking that leaks onto those sources. It fires all four strobes at once and checks the pulse width: a trigger held for two cycles, or OR-ing that drops a source, fails there. It also lands a strobe in the same cycle as a configuration write, mis-addresses a mask write, and resets in the middle of a run, which exposes a select register that is written too early, overwritten by the mask, or not cleared by reset.

// File: rtl/adtrig_pkg.sv
package adtrig_pkg;

    localparam int N_OUT  = 2;               // converters served
    localparam int N_SRC  = 4;               // event sources per output
    localparam int N_CMP  = 2;               // direction-masked sources
    localparam int SEL_W  = N_OUT * N_SRC;   // select register width
    localparam int MASK_W = N_OUT * N_CMP;   // mask register width

    // Bit position of each source inside one output's select nibble
    typedef enum logic [1:0] {
        SRC_UNDERFLOW = 2'd0,
        SRC_CYCLE     = 2'd1,
        SRC_CMP0      = 2'd2,
        SRC_CMP1      = 2'd3
    } src_e;

    typedef enum logic {
        CFG_SEL  = 1'b0,
        CFG_MASK = 1'b1
    } cfg_addr_e;

endpackage

// File: rtl/adtrig_cfg_regs.sv
module adtrig_cfg_regs #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 8,
    parameter int MASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [SEL_W-1:0]  sel_q,
    output logic [MASK_W-1:0] mask_q
);
    import adtrig_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            mask_q <= '0;
        end else if (we) begin
            unique case (cfg_addr_e'(addr))
                CFG_SEL:  sel_q  <= wdata[SEL_W-1:0];
                CFG_MASK: mask_q <= wdata[MASK_W-1:0];
            endcase
        end
    end

endmodule

// File: rtl/adtrig_src_qual.sv
module adtrig_src_qual #(
    parameter int N_SRC = 4,
    parameter int N_CMP = 2
) (
    input  logic [N_SRC-1:0] evt,      // underflow, cycle, cmp0, cmp1
    input  logic             uf_en,
    input  logic             cm_en,
    input  logic             down,
    input  logic [N_SRC-1:0] sel,
    input  logic [N_CMP-1:0] mask,
    output logic             hit
);
    import adtrig_pkg::*;

    localparam int CMP_BASE = int'(SRC_CMP0);

    logic [N_SRC-1:0] gate;

    // Main-timer sources: gated by interrupt-output enables only
    assign gate[SRC_UNDERFLOW] = uf_en;
    assign gate[SRC_CYCLE]     = cm_en;

    // Tuning-timer sources: gated by count direction against mask polarity
    for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
        assign gate[CMP_BASE + c] = (mask[c] == down);
    end

    assign hit = |(evt & sel & gate);

endmodule

// File: rtl/adtrig_pulse_reg.sv
module adtrig_pulse_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end
endmodule

// File: rtl/adtrig_sel.sv
module adtrig_sel #(
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic                         cfg_addr,
    input  logic [DATA_W-1:0]            cfg_wdata,
    input  logic                         uf_evt,
    input  logic                         cm_evt,
    input  logic                         cmp0_evt,
    input  logic                         cmp1_evt,
    input  logic                         uf_irq_en,
    input  logic                         cm_irq_en,
    input  logic                         cnt_down,
    output logic [adtrig_pkg::N_OUT-1:0] adc_trig
);
    import adtrig_pkg::*;

    logic [SEL_W-1:0]  sel_q;
    logic [MASK_W-1:0] mask_q;
    logic [N_SRC-1:0]  evt_vec;
    logic [N_OUT-1:0]  hit;

    assign evt_vec = {cmp1_evt, cmp0_evt, cm_evt, uf_evt};

    adtrig_cfg_regs #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .MASK_W (MASK_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .sel_q  (sel_q),
        .mask_q (mask_q)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        adtrig_src_qual #(
            .N_SRC (N_SRC),
            .N_CMP (N_CMP)
        ) u_qual (
            .evt   (evt_vec),
            .uf_en (uf_irq_en),
            .cm_en (cm_irq_en),
            .down  (cnt_down),
            .sel   (sel_q[o*N_SRC +: N_SRC]),
            .mask  (mask_q[o*N_CMP +: N_CMP]),
            .hit   (hit[o])
        );

        adtrig_pulse_reg u_pulse (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (hit[o]),
            .q     (adc_trig[o])
        );
    end

endmodule

// File: rtl/adtrig_sel_chk.sv
module adtrig_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       uf_evt,
    input logic       cm_evt,
    input logic       cmp0_evt,
    input logic       cmp1_evt,
    input logic       uf_irq_en,
    input logic       cm_irq_en,
    input logic       cnt_down,
    input logic [7:0] sel,
    input logic [3:0] dmask,
    input logic [1:0] adc_trig
);
    logic rst_seen_q = 1'b0;

    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R1: the edge after a reset edge finds both outputs low
    always @(posedge clk) begin
        if (rst_seen_q) begin
            a_reset_idle_r1: assert (adc_trig == 2'b00)
                else $error("reset did not clear triggers");
        end
    end

    // R11: no strobe at all leaves both outputs low next cycle
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(uf_evt || cm_evt || cmp0_evt || cmp1_evt) |=> (adc_trig == 2'b00));

    // R2: enabled, selected underflow fires output 0
    p_uf_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_evt && uf_irq_en && sel[0]) |=> adc_trig[0]);

    // R3: disabled main-timer events alone cause nothing
    p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_evt && !uf_irq_en && !cm_evt && !cmp0_evt && !cmp1_evt) |=> (adc_trig == 2'b00));

    // R5: up-count compare with clear mask fires output 0
    p_cmp_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp0_evt && sel[2] && !dmask[0] && !cnt_down) |=> adc_trig[0]);

    // R6: down-count compare with set mask fires output 1
    p_cmp_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp1_evt && sel[7] && dmask[3] && cnt_down) |=> adc_trig[1]);

    // R6: set mask blocks a lone compare while counting up
    p_cmp_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp0_evt && !cmp1_evt && !uf_evt && !cm_evt && sel[6:0] == 7'b0000100
         && dmask[0] && !cnt_down) |=> !adc_trig[0]);

endmodule

bind adtrig_sel adtrig_sel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .uf_evt    (uf_evt),
    .cm_evt    (cm_evt),
    .cmp0_evt  (cmp0_evt),
    .cmp1_evt  (cmp1_evt),
    .uf_irq_en (uf_irq_en),
    .cm_irq_en (cm_irq_en),
    .cnt_down  (cnt_down),
    .sel       (sel_q),
    .dmask     (mask_q),
    .adc_trig  (adc_trig)
);

// File: tb/adtrig_sel_test.sv
module adtrig_sel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       uf_evt = 1'b0, cm_evt = 1'b0, cmp0_evt = 1'b0, cmp1_evt = 1'b0;
    logic       uf_irq_en = 1'b0, cm_irq_en = 1'b0, cnt_down = 1'b0;
    logic [1:0] adc_trig;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adtrig_sel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .uf_evt    (uf_evt),
        .cm_evt    (cm_evt),
        .cmp0_evt  (cmp0_evt),
        .cmp1_evt  (cmp1_evt),
        .uf_irq_en (uf_irq_en),
        .cm_irq_en (cm_irq_en),
        .cnt_down  (cnt_down),
        .adc_trig  (adc_trig)
    );

    // Vector: req[24:21] sel[20:13] mask[12:9] uf_en cm_en dir uf cm c0 c1 exp[1:0]
    localparam int NV = 15;
    localparam logic [24:0] VEC [NV] = '{
        {4'd2,  8'h01, 4'h0, 3'b110, 4'b1000, 2'b01},  // R2 underflow on out 0
        {4'd3,  8'h01, 4'h0, 3'b010, 4'b1000, 2'b00},  // R3 underflow disabled
        {4'd4,  8'h02, 4'h0, 3'b110, 4'b0100, 2'b01},  // R4 cycle match on out 0
        {4'd3,  8'h20, 4'h0, 3'b100, 4'b0100, 2'b00},  // R3 cycle match disabled
        {4'd5,  8'h04, 4'h0, 3'b000, 4'b0010, 2'b01},  // R5 cmp0 up passes
        {4'd5,  8'h04, 4'h0, 3'b001, 4'b0010, 2'b00},  // R5 cmp0 down blocked
        {4'd6,  8'h08, 4'h2, 3'b001, 4'b0001, 2'b01},  // R6 cmp1 down passes
        {4'd6,  8'h08, 4'h2, 3'b000, 4'b0001, 2'b00},  // R6 cmp1 up blocked
        {4'd7,  8'h11, 4'h0, 3'b111, 4'b1000, 2'b11},  // R7 underflow ignores dir
        {4'd7,  8'h22, 4'hF, 3'b111, 4'b0100, 2'b11},  // R7 cycle ignores mask/dir
        {4'd9,  8'hC0, 4'h4, 3'b001, 4'b0011, 2'b10},  // R9 out1 only, cmp1 blocked
        {4'd8,  8'hFF, 4'h0, 3'b110, 4'b1111, 2'b11},  // R8 all coincide
        {4'd9,  8'h0F, 4'h0, 3'b110, 4'b1000, 2'b01},  // R9 out1 quiet
        {4'd11, 8'h00, 4'h0, 3'b111, 4'b1111, 2'b00},  // R11 nothing selected
        {4'd9,  8'h44, 4'h1, 3'b000, 4'b0010, 2'b10}   // R9 per-output mask
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: adc_trig=%b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic evts(input logic [3:0] e);
        {uf_evt, cm_evt, cmp0_evt, cmp1_evt} = e;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: adc_trig=%b expected run end", adc_trig);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        check("R1", adc_trig, 2'b00);     // reset state
        rst_n = 1'b1;
        tick();
        check("R11", adc_trig, 2'b00);    // idle after reset

        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d", v[24:21]);
            wr(1'b0, v[20:13]);
            wr(1'b1, {4'h0, v[12:9]});
            {uf_irq_en, cm_irq_en, cnt_down} = v[8:6];
            evts(v[5:2]);
            tick();
            check(tag, adc_trig, v[1:0]);
            evts(4'b0000);
            tick();
            check("R8", adc_trig, 2'b00);  // single-cycle pulse
        end

        // R1: reset clears configuration
        wr(1'b0, 8'hFF);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        uf_irq_en = 1'b1; cm_irq_en = 1'b1; cnt_down = 1'b0;
        evts(4'b1111);
        tick();
        check("R1", adc_trig, 2'b00);
        evts(4'b0000);
        tick();

        // R10: strobe during the write uses the old select
        cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 8'h05;
        evts(4'b1000);
        tick();
        cfg_we = 1'b0;
        check("R10", adc_trig, 2'b00);
        tick();
        check("R10", adc_trig, 2'b01);
        evts(4'b0000);

        // R10: mask write leaves select intact, mask from low bits
        wr(1'b1, 8'hFF);
        evts(4'b1000);
        tick();
        check("R10", adc_trig, 2'b01);
        evts(4'b0010); cnt_down = 1'b0;
        tick();
        check("R6", adc_trig, 2'b00);
        cnt_down = 1'b1;
        tick();
        check("R6", adc_trig, 2'b01);
        evts(4'b0000);
        tick();
        check("R11", adc_trig, 2'b00);

        done = 1'b1;
        finish_run();
    end

endmodule